// File: doc/BRIEF.md
# Physical Address Window Router

This block sits on the internal system bus and decides which target interface receives each transaction: the DRAM controller, the PCI Express controller, the local bus, or the serial interconnect. It decodes 36-bit physical addresses that the MMU has already translated, or that a peripheral has already translated on the inbound side. Each transaction is decoded the same way, whatever its source.

Software programs a set of eight windows through a simple write port. Each window holds a base, a power-of-two size, a target code and an enable. A typical map sends 0x0-0x3FFF_FFFF to DRAM, 0x4000_0000-0x4FFF_FFFF to PCI Express, 0x5000_0000-0x5FFF_FFFF to the local bus, and 0x6000_0000 upward to the serial interconnect. Every request is answered one cycle later with the chosen target code, or with a decode error when no enabled window covers the address. The address is passed through unchanged. A window only picks the destination. It never rewrites the address.

Top module: `addr_window_router`

## Requirements
- R1: After reset every window is disabled, `rsp_valid` is low and `req_ready` is high. A request made before any window is programmed returns a decode error.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) produces `rsp_valid` after that edge. The result carries the target code of a covering enabled window, `rsp_hit`=1 and `rsp_err`=0.
- R3: A request that no enabled window covers returns `rsp_err`=1, `rsp_hit`=0 and `rsp_target`=0. Exactly one of `rsp_hit` and `rsp_err` is high while `rsp_valid` is high.
- R4: When several enabled windows cover an address, the window with the lowest index supplies the target.
- R5: A window of size code s covers 2^s bytes. Codes below 12 are treated as 12 (4 KiB). Codes above 36 are treated as 36, which covers the whole space.
- R6: Base bits below the window size are ignored. The window always starts on a boundary aligned to its size.
- R7: `rsp_addr` equals the accepted `req_addr` exactly.
- R8: A window written with `cfg_en`=0 covers nothing, so a later window or a decode error takes its addresses.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the result stays valid and unchanged, and `req_ready` is low.
- R10: A window write on the same edge as an accepted request does not affect that request. It applies from the next accepted request onward.
- R11: With `rsp_ready` held high, a request can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one window |
| cfg_idx | input | 3 | Index of the window being written |
| cfg_base | input | 36 | Window base address |
| cfg_size_log2 | input | 6 | Window size as a power-of-two exponent |
| cfg_target | input | 3 | Target code routed to by the window |
| cfg_en | input | 1 | Window enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 36 | Physical address to decode |
| rsp_valid | output | 1 | Decode result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 36 | Address forwarded unchanged |
| rsp_target | output | 3 | Selected target code, 0 on error |
| rsp_hit | output | 1 | An enabled window covered the address |
| rsp_err | output | 1 | No enabled window covered the address |

## Verification
The assertions assume the consumer of results follows the valid/ready rule. They also assume the request side only raises a transfer it intends to complete. They do not assume the request address stays stable while it waits.

The stimulus keeps address and valid steady until a request is accepted. It toggles `rsp_ready` freely and issues window writes, including one on the same edge as an accepted request. A behavioural model of the window table and a result queue predicts every output on every cycle. The model shifts addresses rather than masking them. It mirrors the register write timing in the order it applies table updates and accepted requests.

// File: rtl/awr_pkg.sv
package awr_pkg;
   localparam int unsigned AWR_SZ_W = 6;
   typedef logic [AWR_SZ_W-1:0] awr_size_t;
endpackage

// File: rtl/awr_window_reg.sv
module awr_window_reg
   import awr_pkg::*;
#(
   parameter int ADDR_W   = 36,
   parameter int TGT_W    = 3,
   parameter int MIN_LOG2 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wr_base,
   input  awr_size_t         wr_size,
   input  logic [TGT_W-1:0]  wr_target,
   input  logic              wr_en,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_mask,
   output logic [TGT_W-1:0]  win_target,
   output logic              win_en
);
   awr_size_t         eff_size;
   logic [ADDR_W-1:0] new_mask;

   always_comb begin
      if (int'(wr_size) < MIN_LOG2)      eff_size = awr_size_t'(MIN_LOG2);
      else if (int'(wr_size) > ADDR_W)   eff_size = awr_size_t'(ADDR_W);
      else                               eff_size = wr_size;
      for (int i = 0; i < ADDR_W; i++)
         new_mask[i] = (i >= int'(eff_size));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_base   <= '0;
         win_mask   <= '0;
         win_target <= '0;
         win_en     <= 1'b0;
      end else if (wr) begin
         win_base   <= wr_base & new_mask;
         win_mask   <= new_mask;
         win_target <= wr_target;
         win_en     <= wr_en;
      end
   end
endmodule

// File: rtl/awr_window_match.sv
module awr_window_match #(
   parameter int ADDR_W = 36
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   input  logic              en,
   output logic              hit
);
   assign hit = en && (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/awr_prio_pick.sv
module awr_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     hits,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/addr_window_router.sv
module addr_window_router
   import awr_pkg::*;
#(
   parameter int ADDR_W   = 36,
   parameter int NUM_WIN  = 8,
   parameter int TGT_W    = 3,
   parameter int MIN_LOG2 = 12,
   localparam int IDX_W   = $clog2(NUM_WIN),
   localparam int SZ_W    = AWR_SZ_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [SZ_W-1:0]   cfg_size_log2,
   input  logic [TGT_W-1:0]  cfg_target,
   input  logic              cfg_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [TGT_W-1:0]  rsp_target,
   output logic              rsp_hit,
   output logic              rsp_err
);
   if (NUM_WIN < 2) begin : g_bad_num
      $error("NUM_WIN must be at least 2");
   end
   if ((1 << SZ_W) <= ADDR_W) begin : g_bad_sz
      $error("size field cannot encode ADDR_W");
   end
   if (MIN_LOG2 < 1 || MIN_LOG2 >= ADDR_W) begin : g_bad_min
      $error("MIN_LOG2 out of range");
   end

   logic [ADDR_W-1:0] w_base   [NUM_WIN];
   logic [ADDR_W-1:0] w_mask   [NUM_WIN];
   logic [TGT_W-1:0]  w_target [NUM_WIN];
   logic [NUM_WIN-1:0] w_en;
   logic [NUM_WIN-1:0] w_hit;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      awr_window_reg #(
         .ADDR_W(ADDR_W), .TGT_W(TGT_W), .MIN_LOG2(MIN_LOG2)
      ) u_reg (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr         (cfg_we && (cfg_idx == IDX_W'(g))),
         .wr_base    (cfg_base),
         .wr_size    (cfg_size_log2),
         .wr_target  (cfg_target),
         .wr_en      (cfg_en),
         .win_base   (w_base[g]),
         .win_mask   (w_mask[g]),
         .win_target (w_target[g]),
         .win_en     (w_en[g])
      );
      awr_window_match #(.ADDR_W(ADDR_W)) u_match (
         .addr (req_addr),
         .base (w_base[g]),
         .mask (w_mask[g]),
         .en   (w_en[g]),
         .hit  (w_hit[g])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] win_sel;

   awr_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
      .hits  (w_hit),
      .found (any_hit),
      .idx   (win_sel)
   );

   logic take;
   assign req_ready = !rsp_valid || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_addr   <= '0;
         rsp_target <= '0;
         rsp_hit    <= 1'b0;
         rsp_err    <= 1'b0;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (take) begin
            rsp_addr   <= req_addr;
            rsp_target <= any_hit ? w_target[win_sel] : '0;
            rsp_hit    <= any_hit;
            rsp_err    <= !any_hit;
         end
      end
   end
endmodule

// File: rtl/addr_window_router_chk.sv
module addr_window_router_chk #(
   parameter int ADDR_W = 36,
   parameter int TGT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [TGT_W-1:0]  rsp_target,
   input logic              rsp_hit,
   input logic              rsp_err
);
   a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid);

   a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> $stable(rsp_addr) && $stable(rsp_target) && $stable(rsp_err));

   a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready);

   a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   a_r7_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid && rsp_addr == $past(req_addr));

   a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> !rsp_hit && rsp_target == '0);

   a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_err}) == 1);

   a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !$past(rsp_valid) |-> $past(req_valid));
endmodule

bind addr_window_router addr_window_router_chk #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .rsp_addr   (rsp_addr),
   .rsp_target (rsp_target),
   .rsp_hit    (rsp_hit),
   .rsp_err    (rsp_err)
);

// File: tb/addr_window_router_tb.sv
`timescale 1ns/1ps
module addr_window_router_tb;
   localparam int AW = 36;
   localparam int NW = 8;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_idx = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [5:0]    cfg_size_log2 = '0;
   logic [TW-1:0] cfg_target = '0;
   logic          cfg_en = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [AW-1:0] rsp_addr;
   logic [TW-1:0] rsp_target;
   logic          rsp_hit;
   logic          rsp_err;

   always #2.5 clk = ~clk;

   addr_window_router u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_base(cfg_base), .cfg_size_log2(cfg_size_log2), .cfg_target(cfg_target),
      .cfg_en(cfg_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_addr(rsp_addr), .rsp_target(rsp_target), .rsp_hit(rsp_hit),
      .rsp_err(rsp_err)
   );

   int total = 0;
   int bad = 0;
   string cur_req = "R1";
   logic last_fire = 1'b0;

   logic [AW-1:0] m_base [NW];
   int            m_sz   [NW];
   logic [TW-1:0] m_tgt  [NW];
   logic          m_en   [NW];

   logic [AW-1:0] q_addr [$];
   logic [TW-1:0] q_tgt  [$];
   logic          q_err  [$];

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   function automatic void predict(input logic [AW-1:0] a, output logic [TW-1:0] t, output logic e);
      e = 1'b1;
      t = '0;
      for (int i = NW - 1; i >= 0; i--)
         if (m_en[i] && ((a >> m_sz[i]) == (m_base[i] >> m_sz[i]))) begin
            e = 1'b0;
            t = m_tgt[i];
         end
   endfunction

   task automatic tick();
      logic [TW-1:0] pt;
      logic          pe;
      int            s;
      #1;
      chk("rsp_valid", 64'(rsp_valid), 64'(q_addr.size() != 0));
      chk("req_ready", 64'(req_ready), 64'(q_addr.size() == 0 || rsp_ready));
      if (rsp_valid && q_addr.size() != 0) begin
         chk("rsp_addr", 64'(rsp_addr), 64'(q_addr[0]));
         chk("rsp_target", 64'(rsp_target), 64'(q_tgt[0]));
         chk("rsp_err", 64'(rsp_err), 64'(q_err[0]));
         chk("rsp_hit", 64'(rsp_hit), 64'(!q_err[0]));
      end
      if (rst_n) begin
         if (rsp_valid && rsp_ready && q_addr.size() != 0) begin
            q_addr.delete(0); q_tgt.delete(0); q_err.delete(0);
         end
         last_fire = req_valid && req_ready;
         if (last_fire) begin
            predict(req_addr, pt, pe);
            q_addr.push_back(req_addr); q_tgt.push_back(pt); q_err.push_back(pe);
         end
         if (cfg_we) begin
            s = int'(cfg_size_log2);
            if (s < 12) s = 12;
            if (s > AW) s = AW;
            m_base[cfg_idx] = cfg_base;
            m_sz[cfg_idx]   = s;
            m_tgt[cfg_idx]  = cfg_target;
            m_en[cfg_idx]   = cfg_en;
         end
      end
      @(negedge clk);
   endtask

   task automatic wr(input int idx, input logic [AW-1:0] b, input int sz, input int t, input logic en);
      cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b;
      cfg_size_log2 = 6'(sz); cfg_target = TW'(t); cfg_en = en;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic rq(input logic [AW-1:0] a);
      req_valid = 1'b1; req_addr = a;
      tick();
      req_valid = 1'b0;
      tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) begin
         m_base[i] = '0; m_sz[i] = 12; m_tgt[i] = '0; m_en[i] = 1'b0;
      end
      @(negedge clk);
      tick(); tick();
      rst_n = 1'b1;
      cur_req = "R1";
      chk("rsp_valid after reset", 64'(rsp_valid), 64'(0));
      chk("req_ready after reset", 64'(req_ready), 64'(1));
      rq(36'h0_0000_1000);

      cur_req = "R2";
      wr(0, 36'h0_0000_0000, 30, 0, 1'b1);
      wr(1, 36'h0_4000_0000, 28, 1, 1'b1);
      wr(2, 36'h0_5000_0000, 28, 2, 1'b1);
      wr(3, 36'h0_6000_0000, 29, 3, 1'b1);
      rq(36'h0_0000_0000); rq(36'h0_3FFF_FFFF); rq(36'h0_4000_0004);
      rq(36'h0_5FFF_FFF3); rq(36'h0_6000_0000); rq(36'h0_7FFF_FFFC);
      cur_req = "R7";
      rq(36'h0_1234_5678); rq(36'h0_4ABC_DEF1);
      cur_req = "R3";
      rq(36'h8_0000_0000); rq(36'h0_8000_0000); rq(36'hF_FFFF_FFFF);

      cur_req = "R4";
      wr(5, 36'h0_4000_0000, 30, 5, 1'b1);
      rq(36'h0_4000_0010); rq(36'h0_7000_0000); rq(36'h0_5555_0000);

      cur_req = "R5";
      wr(6, 36'h9_0000_0000, 3, 6, 1'b1);
      rq(36'h9_0000_0FFF); rq(36'h9_0000_1000); rq(36'h8_FFFF_FFFF);
      cur_req = "R6";
      wr(4, 36'hA_0000_0123, 12, 4, 1'b1);
      rq(36'hA_0000_0000); rq(36'hA_0000_0FFF); rq(36'hA_0000_1000);

      cur_req = "R8";
      wr(1, 36'h0_4000_0000, 28, 1, 1'b0);
      rq(36'h0_4000_0010);
      wr(6, 36'h9_0000_0000, 12, 6, 1'b0);
      rq(36'h9_0000_0010);

      cur_req = "R5";
      wr(7, 36'h0_0000_0000, 50, 7, 1'b1);
      rq(36'h8_0000_0000); rq(36'hF_FFFF_F000); rq(36'h0_0000_0040);

      cur_req = "R10";
      cfg_we = 1'b1; cfg_idx = 3'd0; cfg_base = '0; cfg_size_log2 = 6'd30;
      cfg_target = 3'd0; cfg_en = 1'b0;
      req_valid = 1'b1; req_addr = 36'h0_0000_0100;
      tick();
      cfg_we = 1'b0;
      req_addr = 36'h0_0000_0200;
      tick();
      req_valid = 1'b0;
      tick();

      cur_req = "R11";
      req_valid = 1'b1;
      for (int i = 0; i < 40; i++) begin
         req_addr = {4'(i), 32'(i * 32'h1357_9BDF)};
         tick();
      end
      req_valid = 1'b0;
      tick();

      cur_req = "R9";
      req_valid = 1'b1;
      req_addr = 36'h0_4000_0000;
      for (int i = 0; i < 300; i++) begin
         rsp_ready = 1'($urandom_range(0, 1));
         tick();
         if (last_fire) req_addr = {4'($urandom_range(0, 15)), 32'($urandom)};
      end
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      repeat (4) tick();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule